// File: doc/BRIEF.md
# Parallel Distributed-Arithmetic FIR Filter

This block is a fully parallel FIR filter that needs no multipliers. Each accepted sample goes into a tap delay line. For every bit position of the samples, the bits of the stored taps at that position form an address into a small constant table. Each table entry already holds the sum of the coefficients that the address bits select. A pipelined tree then adds the table outputs two at a time. Before the tree, each table output is shifted by its bit weight. For two's-complement input, the most significant bit slice is also negated.

The taps are split into groups of `GRP` taps, with one table per group and bit slice. Several things are fixed at elaboration: the coefficient set, the tap count, the sample width, the coefficient width and whether the input is signed. A compile-time switch selects how the full-precision output width is found:
- **Worst-case sizing** assumes that any coefficient could reach full scale.
- **Trimming** drops every group whose coefficients are all zero and sizes the output from the actual coefficients.

Both modes give the same arithmetic value. The trimmed output just carries fewer redundant sign bits.

Top module: `da_fir`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `y_out` are driven to zero from the following cycle.
- R2: Each group table returns, for address bit j set, the sum of the coefficients of taps j in the group. The all-zero address returns zero. A single sample of value 1 followed by zeros therefore produces the coefficient sequence in tap order.
- R3: With unsigned input, each output equals the sum over k of coefficient k times the sample accepted k valid cycles earlier. Tap 0 is the newest sample. Coefficient k sits at bits [k*COEF_W +: COEF_W] of `COEFS` as a two's-complement value, and `y_out` is two's complement.
- R4: With `DIN_SIGNED` = 1, samples are read as two's complement. The top bit slice carries negative weight, and outputs match the signed convolution.
- R5: In worst-case sizing, the output width is E + COEF_W + ceil(log2(NTAPS)). E is DIN_W + 1 for unsigned input and DIN_W for signed input. With the defaults this is 24 bits.
- R6: In trimming mode, the output width is E + s + ceil(log2(z)). Here z is the number of nonzero coefficients, and s is the signed width that holds the largest coefficient magnitude m, which is ceil(log2(m+1)) + 1. The defaults give 22 bits unsigned and 21 bits signed.
- R7: For the same coefficients and input, the trimmed output equals the low bits of the worst-case output. The dropped high bits of the worst-case output are copies of the trimmed sign bit.
- R8: The delay line moves only on cycles with `in_valid` high. `din` on other cycles has no effect on any later output.
- R9: `out_valid` rises exactly 1 + ceil(log2(DIN_W × kept groups)) edges after the edge that accepted the sample. This is 6 with the defaults in both modes. Each accepted sample produces exactly one valid output, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `din` at this edge |
| din | input | DIN_W | Input sample |
| out_valid | output | 1 | `y_out` holds a new result |
| y_out | output | OUT_W | Full-precision filter output, two's complement |

## Verification
The assertions rely on these input conditions:
- `rst` is high from time zero.
- `in_valid` and `din` never carry unknown values once reset is released.
- The counter check on accepted versus delivered samples assumes that reset clears the whole pipeline at once.

The stimulus drives defined values on every cycle, including random `din` while `in_valid` is low. It raises `rst` before the first edge and lowers it only at a falling edge. The random phase mixes dense valid runs with short gaps, so the latency and count checks see both back-to-back and sparse traffic.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  localparam int MAX_TAPS = 64;
  localparam int MAX_CW   = 32;

  typedef logic [MAX_TAPS*MAX_CW-1:0] coef_vec_t;

  function automatic int ceil_log2(int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  // two's-complement coefficient idx of width cw
  function automatic longint coef_at(coef_vec_t v, int idx, int cw);
    longint c;
    c = 0;
    for (int b = 0; b < cw; b++) c[b] = v[idx*cw + b];
    if (v[idx*cw + cw - 1]) c = c - (longint'(1) << cw);
    return c;
  endfunction

  function automatic int signed_bits(longint mag);
    return ceil_log2(int'(mag) + 1) + 1;
  endfunction

  function automatic bit group_live(coef_vec_t v, int g, int grp, int taps, int cw);
    for (int j = 0; j < grp; j++) begin
      if ((g*grp + j) < taps && coef_at(v, g*grp + j, cw) != 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int kept_count(coef_vec_t v, int grp, int taps, int cw, bit trim);
    int n;
    n = 0;
    for (int g = 0; g < (taps + grp - 1) / grp; g++)
      if (!trim || group_live(v, g, grp, taps, cw)) n++;
    return n;
  endfunction

  // index of the k-th group that keeps a table
  function automatic int kept_group(coef_vec_t v, int k, int grp, int taps, int cw, bit trim);
    int n;
    n = 0;
    for (int g = 0; g < (taps + grp - 1) / grp; g++) begin
      if (!trim || group_live(v, g, grp, taps, cw)) begin
        if (n == k) return g;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic int out_width(int taps, int dw, int cw, bit sgn, bit trim, coef_vec_t v);
    int     dwe;
    int     nz;
    longint mx;
    longint c;
    dwe = sgn ? dw : dw + 1;
    if (!trim) return dwe + cw + ceil_log2(taps);
    nz = 0;
    mx = 1;
    for (int k = 0; k < taps; k++) begin
      c = coef_at(v, k, cw);
      if (c != 0) nz++;
      if (c < 0) c = -c;
      if (c > mx) mx = c;
    end
    if (nz == 0) nz = 1;
    return dwe + signed_bits(mx) + ceil_log2(nz);
  endfunction

endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter int NTAPS = 5,
  parameter int DIN_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [DIN_W-1:0]       din,
  output logic [NTAPS*DIN_W-1:0] taps_flat
);

  logic [DIN_W-1:0] tap [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) tap[k] <= '0;
    end else if (in_valid) begin
      tap[0] <= din;
      for (int k = 1; k < NTAPS; k++) tap[k] <= tap[k-1];
    end
  end

  always_comb begin
    for (int k = 0; k < NTAPS; k++) taps_flat[k*DIN_W +: DIN_W] = tap[k];
  end

  // R8: an accepted sample lands in the newest tap
  assert_shift_in_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (taps_flat[DIN_W-1:0] == $past(din)));

  // R8: no movement without in_valid
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(taps_flat));

endmodule

// File: rtl/da_fir_rom.sv
module da_fir_rom
  import da_fir_pkg::*;
#(
  parameter int        GN = 2,
  parameter int        CW = 10,
  parameter int        TW = 11,
  parameter coef_vec_t GC = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GN-1:0]        addr,
  output logic signed [TW-1:0] q
);

  localparam int DEPTH = 1 << GN;

  function automatic logic signed [TW-1:0] entry(int a);
    longint s;
    s = 0;
    for (int j = 0; j < GN; j++) if (a[j]) s = s + coef_at(GC, j, CW);
    return TW'(s);
  endfunction

  logic signed [TW-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    assign rom[a] = entry(a);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= rom[addr];
  end

  // R2: no selected tap means no contribution
  assert_zero_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> (q == '0));

endmodule

// File: rtl/da_fir_tree.sv
module da_fir_tree
  import da_fir_pkg::*;
#(
  parameter int N_IN = 20,
  parameter int W    = 22
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_IN*W-1:0]   terms,
  output logic signed [W-1:0] sum
);

  localparam int L = ceil_log2(N_IN);
  localparam int P = 1 << L;

  for (genvar l = 0; l <= L; l++) begin : g_lvl
    logic signed [W-1:0] node [P >> l];
    if (l == 0) begin : g_leaf
      always_comb begin
        for (int i = 0; i < P; i++) node[i] = '0;
        for (int i = 0; i < N_IN; i++) node[i] = terms[i*W +: W];
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < (P >> l); i++) node[i] <= '0;
        end else begin
          for (int i = 0; i < (P >> l); i++)
            node[i] <= g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
        end
      end
    end
  end

  assign sum = g_lvl[L].node[0];

endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int        NTAPS      = 5,
  parameter int        DIN_W      = 10,
  parameter int        COEF_W     = 10,
  parameter int        GRP        = 2,
  parameter bit        DIN_SIGNED = 1'b0,
  parameter bit        TRIM_EN    = 1'b1,
  parameter coef_vec_t COEFS      = coef_vec_t'({10'h000, 10'h3C0, 10'h380, 10'h3C0, 10'h000}),
  parameter int        OUT_W      = out_width(NTAPS, DIN_W, COEF_W, DIN_SIGNED, TRIM_EN, COEFS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DIN_W-1:0] din,
  output logic             out_valid,
  output logic [OUT_W-1:0] y_out
);

  localparam int KEPT   = kept_count(COEFS, GRP, NTAPS, COEF_W, TRIM_EN);
  localparam int TERMS  = KEPT * DIN_W;
  localparam int TREE_L = ceil_log2(TERMS);
  localparam int TW     = COEF_W + ceil_log2(GRP);
  localparam int CNT_W  = ceil_log2(TREE_L + 4) + 1;

  logic [NTAPS*DIN_W-1:0] taps_flat;
  logic                   taps_unused;
  logic signed [TW-1:0]   tq [KEPT][DIN_W];
  logic [TERMS*OUT_W-1:0] terms;
  logic [TREE_L+1:0]      vpipe;

  da_fir_taps #(.NTAPS(NTAPS), .DIN_W(DIN_W)) u_taps (
    .clk, .rst, .in_valid, .din, .taps_flat
  );

  // taps of trimmed groups feed nothing
  assign taps_unused = ^taps_flat;

  for (genvar k = 0; k < KEPT; k++) begin : g_grp
    localparam int        G  = kept_group(COEFS, k, GRP, NTAPS, COEF_W, TRIM_EN);
    localparam int        GN = (NTAPS - G*GRP < GRP) ? (NTAPS - G*GRP) : GRP;
    localparam coef_vec_t GC = COEFS >> (G*GRP*COEF_W);
    for (genvar b = 0; b < DIN_W; b++) begin : g_bit
      logic [GN-1:0] addr;
      always_comb begin
        for (int j = 0; j < GN; j++) addr[j] = taps_flat[(G*GRP + j)*DIN_W + b];
      end
      da_fir_rom #(.GN(GN), .CW(COEF_W), .TW(TW), .GC(GC)) u_rom (
        .clk, .rst, .addr, .q(tq[k][b])
      );
    end
  end

  // weight each slice by 2^b; the sign slice of signed data subtracts
  always_comb begin
    terms = '0;
    for (int k = 0; k < KEPT; k++) begin
      for (int b = 0; b < DIN_W; b++) begin
        logic signed [OUT_W-1:0] e;
        e = OUT_W'(tq[k][b]);
        e = e <<< b;
        if (DIN_SIGNED && b == DIN_W - 1) e = -e;
        terms[(k*DIN_W + b)*OUT_W +: OUT_W] = e;
      end
    end
  end

  da_fir_tree #(.N_IN(TERMS), .W(OUT_W)) u_tree (
    .clk, .rst, .terms, .sum(y_out)
  );

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[TREE_L:0], in_valid};
  end

  assign out_valid = vpipe[TREE_L+1];

  // samples accepted but not yet delivered
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CNT_W'(in_valid) - CNT_W'(out_valid);
  end

  // R9: every output belongs to an accepted sample
  assert_out_has_sample_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight != '0));

  // R9: nothing is held longer than the pipeline depth
  assert_inflight_bound_R9: assert property (@(posedge clk) disable iff (rst)
    inflight <= CNT_W'(TREE_L + 2));

  // R1: reset empties the output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && y_out == '0));

endmodule

// File: tb/da_fir_bench.sv
`timescale 1ns/1ps
module da_fir_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  din = '0;
  logic        vt, vf, vs;
  logic [21:0] yt;
  logic [23:0] yf;
  logic [20:0] ys;

  always #2.5 clk = ~clk;

  da_fir #(.TRIM_EN(1'b1)) u_da_fir (
    .clk, .rst, .in_valid, .din, .out_valid(vt), .y_out(yt));
  da_fir #(.TRIM_EN(1'b0)) u_da_fir_full (
    .clk, .rst, .in_valid, .din, .out_valid(vf), .y_out(yf));
  da_fir #(.TRIM_EN(1'b1), .DIN_SIGNED(1'b1)) u_da_fir_sgn (
    .clk, .rst, .in_valid, .din, .out_valid(vs), .y_out(ys));

  typedef struct {
    longint eu;
    longint es;
    int     stamp;
    int     tag;
  } exp_t;

  exp_t   pend[$];
  int     cyc = 0;
  int     n_checks = 0;
  int     n_fail = 0;
  longint coef [5] = '{0, -64, -128, -64, 0};
  longint hu [5] = '{0, 0, 0, 0, 0};
  longint hs [5] = '{0, 0, 0, 0, 0};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, longint act, longint expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // drive one cycle; accepted samples update the reference model
  task automatic send(logic [9:0] d, bit v, int tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    din = d;
    if (v) begin
      for (int k = 4; k > 0; k--) begin
        hu[k] = hu[k-1];
        hs[k] = hs[k-1];
      end
      hu[0] = longint'(d);
      hs[0] = longint'($signed(d));
      e.eu = 0;
      e.es = 0;
      for (int k = 0; k < 5; k++) begin
        e.eu += coef[k] * hu[k];
        e.es += coef[k] * hs[k];
      end
      e.stamp = cyc + 1;
      e.tag = tag;
      pend.push_back(e);
    end
  endtask

  always @(negedge clk) begin
    if (vt || vf || vs) begin
      chk("R9", longint'({vt, vf, vs}), 7);
      if (pend.size() == 0) begin
        chk("R9", 1, 0);
      end else begin
        exp_t e;
        e = pend.pop_front();
        chk("R9", longint'(cyc - e.stamp), 6);
        case (e.tag)
          2:       chk("R2", longint'($signed(yt)), e.eu);
          8:       chk("R8", longint'($signed(yt)), e.eu);
          default: chk("R3", longint'($signed(yt)), e.eu);
        endcase
        chk("R5", longint'($signed(yf)), e.eu);
        chk("R4", longint'($signed(ys)), e.es);
        chk("R7", longint'(yt), longint'(yf[21:0]));
        chk("R7", longint'(yf[23:21] == 3'b000 || yf[23:21] == 3'b111), 1);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL R9 actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    // R1: reset state on all three variants
    chk("R1", longint'({vt, vf, vs}), 0);
    chk("R1", longint'(yt), 0);
    chk("R1", longint'(yf), 0);
    chk("R1", longint'(ys), 0);
    rst = 1'b0;

    // R5 / R6: port widths
    chk("R5", $bits(u_da_fir_full.y_out), 24);
    chk("R6", $bits(u_da_fir.y_out), 22);
    chk("R6", $bits(u_da_fir_sgn.y_out), 21);

    for (int i = 0; i < 6; i++) send(10'd0, 1'b1, 3);
    for (int i = 0; i < 8; i++) send(10'd1023, 1'b1, 3);
    // R2: impulse reproduces coefficients
    send(10'd1, 1'b1, 2);
    for (int i = 0; i < 6; i++) send(10'd0, 1'b1, 2);
    for (int i = 0; i < 6; i++) send(10'd512, 1'b1, 3);
    for (int i = 0; i < 6; i++) send(10'd511, 1'b1, 3);
    for (int i = 0; i < 8; i++) send((i % 2) ? 10'd1023 : 10'd0, 1'b1, 3);

    // R8: junk on din while idle must not disturb the taps
    send(10'd300, 1'b1, 8);
    send(10'd77, 1'b1, 8);
    for (int i = 0; i < 15; i++) send(10'($urandom % 1024), 1'b0, 8);
    for (int i = 0; i < 6; i++) send(10'd0, 1'b1, 8);

    for (int i = 0; i < 400; i++)
      send(10'($urandom % 1024), ($urandom % 4) != 0, 3);

    for (int i = 0; i < 12; i++) send(10'd0, 1'b0, 3);
    chk("R9", longint'(pend.size()), 0);
    report();
    $finish;
  end

endmodule